// File: doc/BRIEF.md
# Light-Load Burst and Deep-Idle Controller

This block decides, cycle by cycle, whether a switching power stage is allowed to fire at light load. It receives two feedback comparator flags that already carry hysteresis: one says the feedback level sits below the lower burst level, the other says it sits above the upper burst level. When feedback drops low, switching pauses. When feedback climbs back above the upper level, switching resumes. If feedback stays low long enough, the block moves to a deep idle level and raises a flag that also serves as the request for reduced operating current.

Leaving deep idle is not immediate. A timed wake interval follows, then a single-cycle power-on-reset pulse, and only after that pulse is switching enabled again. The block also tells the shutdown-pin sampler how to work. While the stage switches, the sampler takes one sample per gate cycle, timed from the gate-start strobe. While switching is stopped, it samples every cycle.

Both time windows are counted in clock cycles and set by parameters. The defaults assume a 50 MHz clock: 32000 cycles for deep-idle qualification and 1250 cycles for the wake interval. Both values must be at least 2.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset is released, `sw_en`=1 and `deep_idle`, `wake_por`, `sd_cont` and `sd_sample` are all 0.
- R2: While switching runs, a clock edge that samples `fb_below_lo`=1 drives `sw_en` to 0 from the next cycle.
- R3: While paused but not in deep idle, an edge that samples `fb_above_hi`=1 with `fb_below_lo`=0 drives `sw_en` to 1 from the next cycle.
- R4: An edge where both flags are 0 (inside the hysteresis band) leaves the state unchanged: running stays running, paused stays paused, and deep idle stays deep idle.
- R5: `deep_idle`, which is also the low-current request, rises after the edge that samples the ENTRY_CYC-th consecutive `fb_below_lo`=1. The sample that stopped switching counts as the first. The flag then stays high until the exit sequence ends.
- R6: During qualification, a band sample or a rise clears the count. The next low sample then counts as the first again.
- R7: In deep idle, an edge that samples `fb_above_hi`=1 with `fb_below_lo`=0 starts the exit. For the next EXIT_CYC cycles, `deep_idle`=1 and `sw_en`=0. Then `wake_por`=1 for exactly one cycle, with `deep_idle`=0 and `sw_en`=0. After that, `sw_en`=1.
- R8: Once started, the exit sequence runs to completion whatever the feedback flags do. A low flag seen after `sw_en` returns to 1 pauses switching again.
- R9: When both flags are 1, the low flag takes precedence. That sample pauses switching, counts toward deep idle, and does not start an exit.
- R10: `sd_cont`=1 in every cycle where `sw_en`=0. `sd_sample` is 1 in every such cycle. While switching runs, `sd_sample` equals `gate_start` as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_below_lo | input | 1 | Feedback below the lower burst level |
| fb_above_hi | input | 1 | Feedback above the upper burst level |
| gate_start | input | 1 | One-cycle strobe at the start of each gate pulse |
| sw_en | output | 1 | Switching enable |
| deep_idle | output | 1 | Deep idle active; doubles as the low-current request |
| wake_por | output | 1 | One-cycle power-on-reset pulse on deep-idle exit |
| sd_cont | output | 1 | Shutdown sampler mode: 1 = continuous, 0 = once per gate cycle |
| sd_sample | output | 1 | Shutdown sample strobe |

## Verification
A qualification count that is off by one shows at the ports as `deep_idle` rising one cycle early or late. The sweep over pause lengths from 1 to ENTRY_CYC+1 exposes this at the exact boundary. If the count is not cleared, a band sample or a rise during qualification lets `deep_idle` appear before ENTRY_CYC fresh low samples; this is seen within one qualification window. A wrong exit sequence is visible within EXIT_CYC+2 cycles of the rise: the wake pulse is missing or doubled, it sits in the wrong cycle, or `sw_en` comes back while the pulse is high. A wrong sampler mode appears as `sd_sample` failing to follow `gate_start` in the cycle after a switching edge.

// File: rtl/lb_pkg.sv
`timescale 1ns/1ps
package lb_pkg;

  typedef enum logic [2:0] {
    LB_RUN   = 3'd0,
    LB_PAUSE = 3'd1,
    LB_DEEP  = 3'd2,
    LB_WAKE  = 3'd3,
    LB_POR   = 3'd4
  } lb_state_e;

  typedef enum logic [1:0] {
    FB_BAND = 2'd0,
    FB_LOW  = 2'd1,
    FB_HIGH = 2'd2
  } fb_zone_e;

  // The low flag wins when both comparators report at once.
  function automatic fb_zone_e zone_of(input logic below_lo, input logic above_hi);
    if (below_lo)      return FB_LOW;
    else if (above_hi) return FB_HIGH;
    else               return FB_BAND;
  endfunction

endpackage

// File: rtl/lb_fb_zone.sv
`timescale 1ns/1ps
module lb_fb_zone
  import lb_pkg::*;
(
  input  logic     fb_below_lo,
  input  logic     fb_above_hi,
  output fb_zone_e zone
);

  always_comb begin
    zone = zone_of(fb_below_lo, fb_above_hi);
  end

endmodule

// File: rtl/lb_dwell_timer.sv
`timescale 1ns/1ps
module lb_dwell_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R5
  timer_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |-> (cnt != {CNT_W{1'b1}}));

endmodule

// File: rtl/lb_burst_fsm.sv
`timescale 1ns/1ps
module lb_burst_fsm
  import lb_pkg::*;
#(
  parameter int ENTRY_CYC = 32000,
  parameter int EXIT_CYC  = 1250,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  fb_zone_e         zone,
  input  logic [CNT_W-1:0] cnt,
  output lb_state_e        state,
  output lb_state_e        nxt,
  output logic             clr,
  output logic             inc
);

  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  always_comb begin
    nxt = state;
    clr = 1'b1;
    inc = 1'b0;
    unique case (state)
      LB_RUN: begin
        if (zone == FB_LOW) begin
          nxt = LB_PAUSE;
          clr = 1'b0;
          inc = 1'b1;
        end
      end
      LB_PAUSE: begin
        if (zone == FB_LOW) begin
          if (cnt == ENTRY_LAST) begin
            nxt = LB_DEEP;
          end else begin
            clr = 1'b0;
            inc = 1'b1;
          end
        end else if (zone == FB_HIGH) begin
          nxt = LB_RUN;
        end
      end
      LB_DEEP: begin
        if (zone == FB_HIGH) nxt = LB_WAKE;
      end
      LB_WAKE: begin
        if (cnt == EXIT_LAST) begin
          nxt = LB_POR;
        end else begin
          clr = 1'b0;
          inc = 1'b1;
        end
      end
      LB_POR:  nxt = LB_RUN;
      default: nxt = LB_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LB_RUN;
    else     state <= nxt;
  end

  // R8
  wake_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LB_WAKE) |=> (state == LB_WAKE || state == LB_POR));

  // R9
  low_no_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LB_DEEP && zone == FB_LOW) |=> (state == LB_DEEP));

endmodule

// File: rtl/lb_out_stage.sv
`timescale 1ns/1ps
module lb_out_stage
  import lb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lb_state_e nxt,
  input  fb_zone_e  zone,
  input  logic      gate_start,
  output logic      sw_en,
  output logic      deep_idle,
  output logic      wake_por,
  output logic      sd_cont,
  output logic      sd_sample
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en     <= 1'b1;
      deep_idle <= 1'b0;
      wake_por  <= 1'b0;
      sd_cont   <= 1'b0;
      sd_sample <= 1'b0;
    end else begin
      sw_en     <= (nxt == LB_RUN);
      deep_idle <= (nxt == LB_DEEP) || (nxt == LB_WAKE);
      wake_por  <= (nxt == LB_POR);
      sd_cont   <= (nxt != LB_RUN);
      sd_sample <= (nxt != LB_RUN) || gate_start;
    end
  end

  // R2
  pause_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_en && zone == FB_LOW) |=> !sw_en);

  // R3
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && !deep_idle && zone == FB_HIGH) |=> sw_en);

  // R5
  deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(deep_idle) |-> $past(zone == FB_LOW));

  // R7
  por_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_por |=> (!wake_por && sw_en && !deep_idle));

  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (deep_idle && zone == FB_HIGH) |=> (deep_idle || wake_por));

  // R10
  sd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> (sd_cont && sd_sample));

endmodule

// File: rtl/lightload_burst_ctrl.sv
`timescale 1ns/1ps
module lightload_burst_ctrl
  import lb_pkg::*;
#(
  parameter int ENTRY_CYC = 32000,
  parameter int EXIT_CYC  = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_below_lo,
  input  logic fb_above_hi,
  input  logic gate_start,
  output logic sw_en,
  output logic deep_idle,
  output logic wake_por,
  output logic sd_cont,
  output logic sd_sample
);

  localparam int CNT_MAX = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fb_zone_e         zone;
  lb_state_e        state;
  lb_state_e        nxt;
  logic             tmr_clr;
  logic             tmr_inc;
  logic [CNT_W-1:0] tmr_cnt;

  lb_fb_zone u_zone (
    .fb_below_lo (fb_below_lo),
    .fb_above_hi (fb_above_hi),
    .zone        (zone)
  );

  lb_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .inc (tmr_inc),
    .cnt (tmr_cnt)
  );

  lb_burst_fsm #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .zone  (zone),
    .cnt   (tmr_cnt),
    .state (state),
    .nxt   (nxt),
    .clr   (tmr_clr),
    .inc   (tmr_inc)
  );

  lb_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .nxt        (nxt),
    .zone       (zone),
    .gate_start (gate_start),
    .sw_en      (sw_en),
    .deep_idle  (deep_idle),
    .wake_por   (wake_por),
    .sd_cont    (sd_cont),
    .sd_sample  (sd_sample)
  );

endmodule

// File: tb/lightload_burst_ctrl_bench.sv
`timescale 1ns/1ps
module lightload_burst_ctrl_bench;

  localparam int ENTRY = 8;
  localparam int EXITC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_below_lo = 1'b0;
  logic fb_above_hi = 1'b0;
  logic gate_start = 1'b0;
  logic sw_en, deep_idle, wake_por, sd_cont, sd_sample;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lightload_burst_ctrl #(.ENTRY_CYC(ENTRY), .EXIT_CYC(EXITC)) u_lightload_burst_ctrl (
    .clk         (clk),
    .rst         (rst),
    .fb_below_lo (fb_below_lo),
    .fb_above_hi (fb_above_hi),
    .gate_start  (gate_start),
    .sw_en       (sw_en),
    .deep_idle   (deep_idle),
    .wake_por    (wake_por),
    .sd_cont     (sd_cont),
    .sd_sample   (sd_sample)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, and return at the next falling edge.
  task automatic tick(input logic lo, input logic hi, input logic g);
    fb_below_lo = lo;
    fb_above_hi = hi;
    gate_start  = g;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Exit from deep idle; lo_in is held during the sequence (R8).
  task automatic wake_seq(input logic lo_in);
    tick(1'b0, 1'b1, 1'b0);
    chk("R7 wake start deep_idle", deep_idle, 1);
    chk("R7 wake start sw_en", sw_en, 0);
    chk("R7 wake start wake_por", wake_por, 0);
    for (int j = 1; j < EXITC; j++) begin
      tick(lo_in, 1'b0, 1'b1);
      chk("R7 wake hold deep_idle", deep_idle, 1);
      chk("R8 wake hold wake_por", wake_por, 0);
      chk("R10 wake sd_sample", sd_sample, 1);
    end
    tick(lo_in, 1'b0, 1'b0);
    chk("R7 por pulse", wake_por, 1);
    chk("R7 por deep_idle low", deep_idle, 0);
    chk("R7 por sw_en low", sw_en, 0);
    tick(lo_in, 1'b0, 1'b0);
    chk("R7 after por sw_en", sw_en, 1);
    chk("R7 after por wake_por", wake_por, 0);
    if (lo_in) begin
      tick(1'b1, 1'b0, 1'b0);
      chk("R8 low after exit pauses", sw_en, 0);
      tick(1'b0, 1'b1, 1'b0);
      chk("R3 resume after exit", sw_en, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset sw_en", sw_en, 1);
    chk("R1 reset deep_idle", deep_idle, 0);
    chk("R1 reset wake_por", wake_por, 0);
    chk("R1 reset sd_cont", sd_cont, 0);
    chk("R1 reset sd_sample", sd_sample, 0);

    // R10: strobe follows gate_start while running
    tick(1'b0, 1'b0, 1'b1);
    chk("R10 run sample follows gate", sd_sample, 1);
    chk("R10 run sd_cont", sd_cont, 0);
    tick(1'b0, 1'b0, 1'b0);
    chk("R10 run no gate no sample", sd_sample, 0);

    // R5/R2: sweep pause length over the entry boundary
    for (int k = 1; k <= ENTRY + 1; k++) begin
      for (int i = 1; i <= k; i++) begin
        tick(1'b1, 1'b0, logic'(i % 2));
        chk("R2 low pauses", sw_en, 0);
        chk("R5 deep entry boundary", deep_idle, (i >= ENTRY) ? 1 : 0);
        chk("R10 paused sd_cont", sd_cont, 1);
        chk("R10 paused sd_sample", sd_sample, 1);
      end
      if (k >= ENTRY) wake_seq(logic'(k % 2));
      else begin
        tick(1'b0, 1'b1, 1'b0);
        chk("R3 rise resumes", sw_en, 1);
        chk("R3 no deep after short pause", deep_idle, 0);
      end
    end

    // R4: band holds running and paused states
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 1'b0);
      chk("R4 band keeps running", sw_en, 1);
    end
    tick(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 1'b0);
      chk("R4 band keeps paused", sw_en, 0);
      chk("R4 band no deep", deep_idle, 0);
    end
    tick(1'b0, 1'b1, 1'b0);
    chk("R3 resume after band", sw_en, 1);

    // R6: band interruption at every position restarts qualification
    for (int b = 1; b < ENTRY; b++) begin
      for (int i = 0; i < b; i++) tick(1'b1, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0);
      chk("R6 band paused", sw_en, 0);
      for (int i = 1; i <= ENTRY; i++) begin
        tick(1'b1, 1'b0, 1'b0);
        chk("R6 band restarts count", deep_idle, (i >= ENTRY) ? 1 : 0);
      end
      wake_seq(1'b0);
    end

    // R6: rise interruption restarts qualification
    for (int b = 1; b < ENTRY; b++) begin
      for (int i = 0; i < b; i++) tick(1'b1, 1'b0, 1'b0);
      tick(1'b0, 1'b1, 1'b0);
      chk("R6 rise resumes", sw_en, 1);
      for (int i = 1; i <= ENTRY; i++) begin
        tick(1'b1, 1'b0, 1'b0);
        chk("R6 rise restarts count", deep_idle, (i >= ENTRY) ? 1 : 0);
      end
      wake_seq(1'b0);
    end

    // R9: both flags high act as low
    for (int i = 1; i <= ENTRY; i++) begin
      tick(1'b1, 1'b1, 1'b0);
      chk("R9 both high pauses", sw_en, 0);
      chk("R9 both high counts", deep_idle, (i >= ENTRY) ? 1 : 0);
    end
    for (int i = 0; i < EXITC + 2; i++) begin
      tick(1'b1, 1'b1, 1'b0);
      chk("R9 both high no exit", deep_idle, 1);
      chk("R9 both high no por", wake_por, 0);
    end
    // R4: band holds deep idle
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 1'b0);
      chk("R4 band keeps deep", deep_idle, 1);
      chk("R4 band deep no por", wake_por, 0);
    end
    wake_seq(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule